// File: doc/BRIEF.md
# Prescaled 64-bit Time Base Counter

A free-running 64-bit counter used as a shared time reference. It advances by one on every fourth enabled clock cycle, driven by an internal divide-by-four prescaler, and it stops while its count gate input is low. The count is stored as a low 32-bit word and a high 32-bit word. A carry out of the low word moves into the high word, so the two words form a single 64-bit value.

Software reaches the two words through a small register port, one word per access. There is no single 64-bit read. Reads work at any privilege level. Writes change the count only when the access is marked supervisor. A write marked user changes nothing and raises a one-cycle error pulse. Software that needs a consistent 64-bit value reads high, then low, then high again, and repeats the sequence if the two high reads differ.

Top module: `time_base_ctr`

## Requirements
- R1: While rst_ni is low, both words and the prescaler are zero. The first reads after reset return 0 for both words.
- R2: While cnt_en_i is high, the 64-bit count increases by exactly one on every fourth rising clock edge. Between two increments it holds for three edges.
- R3: When the low word is 0xFFFFFFFF and an increment occurs, the low word becomes 0 and the high word increases by one.
- R4: While cnt_en_i is low, neither the count nor the prescaler moves.
- R5: A read is a one-cycle pulse on rd_i. Address 0 returns the low word and address 1 returns the high word. Addresses 2 and 3 return 0. The value appears on rdata_o on the clock after the read and shows the count as it was before that edge. rdata_o is 0 in any cycle that does not follow a read.
- R6: Reads return the same data whether sup_i is high or low.
- R7: A write with sup_i high to address 0 or 1 loads wdata_i into that word on the next edge. The other word keeps its value. A write with sup_i high to address 2 or 3 has no effect.
- R8: A write with sup_i high to address 0 or 1 clears the prescaler. If an increment falls on the same edge, the written value is kept and the increment is dropped. The next increment comes four enabled cycles after the write.
- R9: A write with sup_i low leaves both words and the prescaler unchanged. err_o is then high for exactly the next cycle, and err_o is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count gate; the count and the prescaler advance only while it is high |
| addr_i | input | 2 | Word select: 0 for the low word, 1 for the high word |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| sup_i | input | 1 | High for a supervisor-level access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid on the cycle after rd_i |
| err_o | output | 1 | One-cycle pulse after a user-level write |

## Verification
The count is only visible through reads, so a wrong state shows up on the next read of the affected word. That read returns its data one cycle after rd_i. A prescaler that is off by one does not give a wrong value at once. Instead an increment lands one edge early or late, and a reference model that tracks every cycle sees the mismatch on the first read near that increment. Faults in the carry or in the privilege gate appear when the low word wraps or after a user write. For that reason the bench reads repeatedly around writes, wraps and gate changes, and also runs a long stretch of mixed random accesses.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  parameter int unsigned TB_W   = 64;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned ADDR_W = 2;
  parameter int unsigned DIV    = 4;
  localparam int unsigned NW    = TB_W / WORD_W;

  typedef struct packed {
    logic [NW-1:0] wr_sel;
    logic          priv_err;
  } acc_dec_t;
endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (en_i) begin
      if (cnt_q == LAST)  cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  // a clear suppresses a tick in the same cycle
  assign tick_o = en_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/tbase_words.sv
module tbase_words #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NW     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 inc_i,
  input  logic [NW-1:0]        wr_sel_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [NW*WORD_W-1:0] count_o
);
  logic [NW:0] carry;
  assign carry[0] = inc_i;

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          word_q <= '0;
      else if (wr_sel_i[g]) word_q <= wdata_i;
      else if (carry[g])    word_q <= word_q + 1'b1;
    end

    assign carry[g+1] = carry[g] && (&word_q);
    assign count_o[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/tbase_regif.sv
module tbase_regif
  import tbase_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned NW     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic                 sup_i,
  input  logic [NW*WORD_W-1:0] count_i,
  output acc_dec_t             dec_o,
  output logic [WORD_W-1:0]    rdata_o,
  output logic                 err_o
);
  logic              hit;
  logic [WORD_W-1:0] rd_mux;
  logic [WORD_W-1:0] rdata_q;
  logic              err_q;

  assign hit = ({{(32-ADDR_W){1'b0}}, addr_i} < NW);

  always_comb begin
    dec_o = '0;
    rd_mux = '0;
    for (int i = 0; i < NW; i++) begin
      if (hit && addr_i == ADDR_W'(i)) begin
        dec_o.wr_sel[i] = wr_i && sup_i;
        rd_mux          = count_i[i*WORD_W +: WORD_W];
      end
    end
    dec_o.priv_err = wr_i && !sup_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rd_i ? rd_mux : '0;
      err_q   <= dec_o.priv_err;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/time_base_ctr.sv
module time_base_ctr
  import tbase_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              sup_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              err_o
);
  acc_dec_t         dec;
  logic             tick;
  logic             any_wr;
  logic [TB_W-1:0]  count;

  assign any_wr = |dec.wr_sel;

  tbase_regif #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NW(NW)) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .sup_i   (sup_i),
    .count_i (count),
    .dec_o   (dec),
    .rdata_o (rdata_o),
    .err_o   (err_o)
  );

  tbase_prescale #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en_i),
    .clr_i  (any_wr),
    .tick_o (tick)
  );

  tbase_words #(.WORD_W(WORD_W), .NW(NW)) u_words (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (tick),
    .wr_sel_i (dec.wr_sel),
    .wdata_i  (wdata_i),
    .count_o  (count)
  );
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk
  import tbase_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnt_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              sup_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              err_o,
  input logic [TB_W-1:0]   count
);
  // R2: at most one step per edge when no write lands
  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sup_i) |=> (count == $past(count)) || (count == $past(count) + 1'b1));

  // R2: after an increment the count holds on the next edge
  p_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count != $past(count) && !$past(wr_i) && !wr_i) |=> $stable(count));

  p_gate_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !wr_i) |=> $stable(count));

  p_rd_bad_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i >= ADDR_W'(NW)) |=> (rdata_o == '0));

  p_rd_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));

  p_wr_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sup_i && addr_i == '0) |=>
      (count[WORD_W-1:0] == $past(wdata_i)) && (count[TB_W-1:WORD_W] == $past(count[TB_W-1:WORD_W])));

  p_wr_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sup_i && addr_i == ADDR_W'(1)) |=>
      (count[TB_W-1:WORD_W] == $past(wdata_i)) && (count[WORD_W-1:0] == $past(count[WORD_W-1:0])));

  p_user_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sup_i && !cnt_en_i) |=> $stable(count));

  p_err_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sup_i) |=> err_o);

  p_err_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !sup_i) |=> !err_o);
endmodule

bind time_base_ctr tbase_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_en_i (cnt_en_i),
  .addr_i   (addr_i),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .sup_i    (sup_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .err_o    (err_o),
  .count    (count)
);

// File: tb/time_base_ctr_tb.sv
module time_base_ctr_tb;
  localparam time CLK_P = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        cnt_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic        sup_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;

  time_base_ctr u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .addr_i(addr_i),
    .rd_i(rd_i), .wr_i(wr_i), .sup_i(sup_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .err_o(err_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  // reference model built from the requirements
  logic [63:0] m_cnt;
  int          m_pre;
  logic        m_err;
  logic        m_rd;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = '0; m_pre = 0; m_err = 1'b0; m_rd = 1'b0;
    end else begin
      m_rd  = rd_i;
      m_err = wr_i && !sup_i;
      if (wr_i && sup_i && addr_i < 2) begin
        if (addr_i == 0) m_cnt[31:0]  = wdata_i;
        else             m_cnt[63:32] = wdata_i;
        m_pre = 0;
      end else if (cnt_en_i) begin
        if (m_pre == 3) begin m_cnt = m_cnt + 1; m_pre = 0; end
        else m_pre = m_pre + 1;
      end
    end
  end

  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(err_o == m_err, "R9 err_o", {31'b0, err_o}, {31'b0, m_err});
      if (m_rd) begin
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected read", rdata_o, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rdata_o == e, t, rdata_o, e);
        end
      end else begin
        check(rdata_o == 32'h0, "R5 idle rdata", rdata_o, 32'h0);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d, input bit s);
    addr_i = a; wdata_i = d; sup_i = s; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; sup_i = 1'b0;
  endtask

  // driver: pushes the value the read must return
  task automatic do_rd(input logic [1:0] a, input bit s, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr_i = a; sup_i = s; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0; sup_i = 1'b0;
  endtask

  function automatic logic [31:0] mval(input logic [1:0] a);
    return (a == 0) ? m_cnt[31:0] : (a == 1) ? m_cnt[63:32] : 32'h0;
  endfunction

  task automatic rd_model(input logic [1:0] a, input bit s, input string tag);
    do_rd(a, s, mval(a), tag);
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    do_rd(2'd0, 1'b0, 32'h0, "R1 low after reset");
    do_rd(2'd1, 1'b1, 32'h0, "R1 high after reset");

    // R2: steady counting
    cnt_en_i = 1'b1;
    idle(9);
    rd_model(2'd0, 1'b0, "R2 low after counting");
    idle(5);
    rd_model(2'd0, 1'b1, "R2 low later");

    // R3, R7, R8: carry from a loaded value
    do_wr(2'd0, 32'hFFFF_FFFF, 1'b1);
    do_wr(2'd1, 32'h0000_0005, 1'b1);
    idle(8);
    do_rd(2'd1, 1'b0, 32'h0000_0006, "R3 high after wrap");
    do_rd(2'd0, 1'b1, 32'h0000_0001, "R3 low after wrap");

    // R7: write of one word leaves the other
    do_wr(2'd1, 32'hA5A5_0000, 1'b1);
    rd_model(2'd1, 1'b0, "R7 high written");
    rd_model(2'd0, 1'b0, "R7 low kept");

    // R8: prescaler restart after a write
    do_wr(2'd0, 32'h0000_0100, 1'b1);
    idle(2);
    do_rd(2'd0, 1'b0, 32'h0000_0100, "R8 no early increment");
    do_rd(2'd0, 1'b0, 32'h0000_0100, "R8 still held");
    do_rd(2'd0, 1'b0, 32'h0000_0101, "R8 increment four after write");

    // R4: gate low
    cnt_en_i = 1'b0;
    idle(2);
    rd_model(2'd0, 1'b0, "R4 before hold");
    idle(17);
    rd_model(2'd0, 1'b1, "R4 held low word");
    rd_model(2'd1, 1'b0, "R4 held high word");

    // R9: user write ignored
    do_wr(2'd0, 32'hDEAD_BEEF, 1'b0);
    rd_model(2'd0, 1'b0, "R9 user write ignored low");
    do_wr(2'd1, 32'hDEAD_BEEF, 1'b0);
    rd_model(2'd1, 1'b1, "R9 user write ignored high");
    cnt_en_i = 1'b1;

    // R5, R7: unmapped addresses
    do_wr(2'd2, 32'h1234_5678, 1'b1);
    do_rd(2'd2, 1'b1, 32'h0, "R5 address 2 reads zero");
    do_rd(2'd3, 1'b0, 32'h0, "R5 address 3 reads zero");
    rd_model(2'd0, 1'b0, "R7 unmapped write ignored");

    // R6: same data at both levels
    cnt_en_i = 1'b0;
    rd_model(2'd1, 1'b0, "R6 user read high");
    rd_model(2'd1, 1'b1, "R6 supervisor read high");
    cnt_en_i = 1'b1;

    // R3: near-wrap value with mixed traffic
    do_wr(2'd0, 32'hFFFF_FFFD, 1'b1);
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom;
      cnt_en_i = (r[7:4] != 0);
      case (r[3:0])
        4'd0:    do_wr(r[9:8], $urandom, 1'b1);
        4'd1:    do_wr(r[9:8], $urandom, 1'b0);
        4'd2:    do_wr(2'd0, 32'hFFFF_FFFE, 1'b1);
        4'd3, 4'd4, 4'd5, 4'd6, 4'd7:
                 rd_model(r[9:8], r[10], "R2 R3 R8 mixed read");
        default: idle(1);
      endcase
    end
    cnt_en_i = 1'b0;
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule